// File: doc/BRIEF.md
# Edge-Activity Watchdog with Early-Warning Pulse

This block supervises a processor by watching a single activity line. Every change of level on that line counts as a sign of life and restarts a timeout. When a whole timeout passes without a change, the block drives a short active-low warning pulse. After a small fixed number of clock cycles it drops a sustained active-low fault level. The fault level stays low until the activity line changes again. Because the warning edge always comes first, an external flop clocked by the warning pulse can sample the fault level and record a second consecutive fault. On the first fault it still sees the fault level high.

The timeout is counted in ticks of an internal prescaler, so it has a real-time meaning. One mode input selects either a fixed default tick count or an alternate count. The alternate count is a small setting multiplied by a fixed number of ticks per unit, so it scales linearly with that setting. The activity line arrives as two synchronous signals: its logic level, and a flag that marks it as left floating at mid-supply. A floating line turns the watchdog off. The block is also turned off by three other inputs: a system reset, battery-backup mode and a manual reset. While it is off, both outputs are high and the timer is held cleared.

Top module: `wdg_pulse_guard`

## Requirements
- R1: While `rst_n` is low at a clock edge, `warn_n` and `fault_n` are 1 after that edge. The timeout is measured from the last edge at which `rst_n` was low.
- R2: While the block is enabled, a change of `wd_level` between two consecutive edges restarts the timeout. This holds for a rise and for a fall, and a one-cycle pulse gives two restarts. The next expiry comes exactly N edges after the last restarting edge, with no expiry before it.
- R3: N is `DEF_TICKS*TICK_DIV` clock cycles when `alt_mode` is 0. When `alt_mode` is 1, N is `max(alt_units,1)*ALT_STEP*TICK_DIV` clock cycles; a setting of 0 counts as 1.
- R4: On expiry, `warn_n` is low for exactly `PULSE_CYC` consecutive cycles and then returns high. A change of `wd_level` does not shorten the pulse.
- R5: `fault_n` falls exactly `FAULT_DLY` edges (at least 1) after `warn_n` falls, while `warn_n` is still low.
- R6: Once low, `fault_n` stays low until `wd_level` changes, and it returns high at the edge that sees the change. A change that comes before the delay of R5 runs out cancels the pending fault, so `fault_n` does not fall.
- R7: If timeouts keep expiring with no change of `wd_level`, `warn_n` pulses once every N cycles while `fault_n` stays low.
- R8: While `wd_float` is 1, both outputs are 1 from the next edge on and the timer is held cleared. Changes of `wd_level` have no effect during that time. After release, the timeout counts from the last floating edge.
- R9: `sys_rst_act` or `batt_act` at 1 has the same effect as R8.
- R10: `man_rst` at 1 has the same effect as R8. This clears the timer and drives both outputs high.
- R11: If the selected count is changed to a value at or below the ticks already elapsed, the expiry happens at the next tick boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wd_level | input | 1 | Synchronous logic level of the activity line |
| wd_float | input | 1 | 1 = activity line is floating at mid-level (watchdog off) |
| alt_mode | input | 1 | 0 = default timeout, 1 = alternate timeout |
| alt_units | input | SET_W | Alternate timeout setting, in units of ALT_STEP ticks |
| sys_rst_act | input | 1 | System reset is asserted (watchdog off) |
| batt_act | input | 1 | Battery-backup mode is active (watchdog off) |
| man_rst | input | 1 | Manual reset is asserted (watchdog off, timer cleared) |
| warn_n | output | 1 | Active-low early-warning pulse |
| fault_n | output | 1 | Active-low sustained fault level |

## Verification
The bench builds the block with a prescaler of 4 cycles, a default of 20 ticks (80 cycles), 3 ticks per alternate unit, a 4-bit setting, a 5-cycle warning pulse and a 2-cycle fault delay. With these small values, repeated expiries, the cancel window between the warning edge and the fault edge, and limit changes in the middle of a tick all occur within a few thousand cycles. The 2-cycle delay also shows that the fault edge lags the warning edge by more than one register stage. Settings up to 15 give alternate timeouts from 12 to 180 cycles, so random activity lands both before and after expiry.

// File: rtl/wdg_pkg.sv
// Package: shared types for the edge-activity watchdog.
// Assumes: all users run on one clock domain.
package wdg_pkg;

    // Qualified activity event produced once per cycle by the input stage.
    typedef struct packed {
        logic enable;   // watchdog is allowed to run this cycle
        logic kick;     // level change seen while enabled
    } wdg_evt_t;

endpackage

// File: rtl/wdg_activity.sv
// Module: wdg_activity
// Turns the synchronous activity level into a one-cycle kick event and
// merges every disabling condition into a single enable.
// Assumes: inputs are already synchronous to clk; the previous level is
// tracked even while disabled, so leaving a disabled state never kicks.
module wdg_activity
    import wdg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wd_level,
    input  logic     wd_float,
    input  logic     sys_rst_act,
    input  logic     batt_act,
    input  logic     man_rst,
    output wdg_evt_t evt
);

    logic lvl_q;
    logic run_ok;

    // Purpose: remember the level seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= wd_level;
        end else begin
            lvl_q <= wd_level;
        end
    end

    // Purpose: form the enable and the qualified kick for this cycle.
    always_comb begin
        run_ok     = rst_n && !wd_float && !sys_rst_act && !batt_act && !man_rst;
        evt.enable = run_ok;
        evt.kick   = run_ok && (wd_level != lvl_q);
    end

endmodule

// File: rtl/wdg_timeout.sv
// Module: wdg_timeout
// Prescaler plus tick counter. Raises a one-cycle expire strobe when the
// selected number of ticks has passed since the last restart.
// Assumes: a restart (kick or disable) clears both counters; the limit
// may change at any time and is compared with >= at tick boundaries.
module wdg_timeout
    import wdg_pkg::*;
#(
    parameter int TICK_DIV  = 25000,
    parameter int DEF_TICKS = 16000,
    parameter int ALT_STEP  = 21,
    parameter int SET_W     = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wdg_evt_t         evt,
    input  logic             alt_mode,
    input  logic [SET_W-1:0] alt_units,
    output logic             expire
);

    localparam int ALT_MAX = ((1 << SET_W) - 1) * ALT_STEP;
    localparam int LIM_MAX = (DEF_TICKS > ALT_MAX) ? DEF_TICKS : ALT_MAX;
    localparam int TICK_W  = $clog2(LIM_MAX + 1);

    logic [TICK_W-1:0] limit;
    logic [TICK_W-1:0] ticks;
    logic [TICK_W:0]   ticks_nx;
    logic [SET_W-1:0]  units_eff;
    logic              last_pre;
    logic              restart;

    // Purpose: choose the tick limit for the current mode.
    always_comb begin
        units_eff = (alt_units == '0) ? SET_W'(1) : alt_units;
        if (alt_mode) begin
            limit = TICK_W'(int'(units_eff) * ALT_STEP);
        end else begin
            limit = TICK_W'(DEF_TICKS);
        end
    end

    // Purpose: decide restart and expiry for this cycle.
    always_comb begin
        restart  = !evt.enable || evt.kick;
        ticks_nx = {1'b0, ticks} + 1'b1;
        expire   = !restart && last_pre && (ticks_nx >= {1'b0, limit});
    end

    generate
        if (TICK_DIV == 1) begin : g_no_pre
            // Purpose: every cycle is a tick boundary.
            always_comb last_pre = 1'b1;
        end else begin : g_pre
            localparam int PRE_W = $clog2(TICK_DIV);
            logic [PRE_W-1:0] pre;

            // Purpose: flag the last cycle of the current tick.
            always_comb last_pre = (pre == PRE_W'(TICK_DIV - 1));

            // Purpose: count cycles within one tick.
            always_ff @(posedge clk) begin
                if (!rst_n || restart || expire || last_pre) begin
                    pre <= '0;
                end else begin
                    pre <= pre + 1'b1;
                end
            end
        end
    endgenerate

    // Purpose: count whole ticks since the last restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || expire) begin
            ticks <= '0;
        end else if (last_pre) begin
            ticks <= ticks + 1'b1;
        end
    end

endmodule

// File: rtl/wdg_alarm.sv
// Module: wdg_alarm
// Drives the warning pulse and the sustained fault level. The fault edge
// trails the warning edge by FAULT_DLY cycles through a short delay line.
// Assumes: FAULT_DLY >= 1 and PULSE_CYC > FAULT_DLY; expiries are spaced
// further apart than PULSE_CYC.
module wdg_alarm
    import wdg_pkg::*;
#(
    parameter int PULSE_CYC = 250000,
    parameter int FAULT_DLY = 18
) (
    input  logic     clk,
    input  logic     rst_n,
    input  wdg_evt_t evt,
    input  logic     expire,
    output logic     warn_n,
    output logic     fault_n
);

    localparam int PW_W = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;

    logic [PW_W-1:0]      pw_left;
    logic [FAULT_DLY-1:0] dly_sh;
    logic                 dly_out;

    // Purpose: generate the fixed-width active-low warning pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !evt.enable) begin
            warn_n  <= 1'b1;
            pw_left <= '0;
        end else if (expire) begin
            warn_n  <= 1'b0;
            pw_left <= PW_W'(PULSE_CYC - 1);
        end else if (!warn_n) begin
            if (pw_left == '0) begin
                warn_n <= 1'b1;
            end else begin
                pw_left <= pw_left - 1'b1;
            end
        end
    end

    generate
        if (FAULT_DLY == 1) begin : g_dly1
            // Purpose: single-stage delay from expiry to fault.
            always_ff @(posedge clk) begin
                if (!rst_n || !evt.enable || evt.kick) begin
                    dly_sh <= '0;
                end else begin
                    dly_sh <= expire;
                end
            end
        end else begin : g_dlyn
            // Purpose: multi-stage delay from expiry to fault.
            always_ff @(posedge clk) begin
                if (!rst_n || !evt.enable || evt.kick) begin
                    dly_sh <= '0;
                end else begin
                    dly_sh <= {dly_sh[FAULT_DLY-2:0], expire};
                end
            end
        end
    endgenerate

    assign dly_out = dly_sh[FAULT_DLY-1];

    // Purpose: set the fault level after the delay; clear it on activity.
    always_ff @(posedge clk) begin
        if (!rst_n || !evt.enable || evt.kick) begin
            fault_n <= 1'b1;
        end else if (dly_out) begin
            fault_n <= 1'b0;
        end
    end

endmodule

// File: rtl/wdg_pulse_guard.sv
// Module: wdg_pulse_guard (top)
// Edge-activity watchdog with an early-warning pulse and a trailing fault
// level. Chains the input stage, the timeout counter and the alarm stage.
// Assumes: PULSE_CYC < ALT_STEP*TICK_DIV and PULSE_CYC < DEF_TICKS*TICK_DIV
// (pulses never overlap), 1 <= FAULT_DLY < PULSE_CYC.
module wdg_pulse_guard
    import wdg_pkg::*;
#(
    parameter int TICK_DIV  = 25000,
    parameter int DEF_TICKS = 16000,
    parameter int ALT_STEP  = 21,
    parameter int SET_W     = 7,
    parameter int PULSE_CYC = 250000,
    parameter int FAULT_DLY = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wd_level,
    input  logic             wd_float,
    input  logic             alt_mode,
    input  logic [SET_W-1:0] alt_units,
    input  logic             sys_rst_act,
    input  logic             batt_act,
    input  logic             man_rst,
    output logic             warn_n,
    output logic             fault_n
);

    wdg_evt_t evt;
    logic     expire;

    wdg_activity u_act (
        .clk         (clk),
        .rst_n       (rst_n),
        .wd_level    (wd_level),
        .wd_float    (wd_float),
        .sys_rst_act (sys_rst_act),
        .batt_act    (batt_act),
        .man_rst     (man_rst),
        .evt         (evt)
    );

    wdg_timeout #(
        .TICK_DIV  (TICK_DIV),
        .DEF_TICKS (DEF_TICKS),
        .ALT_STEP  (ALT_STEP),
        .SET_W     (SET_W)
    ) u_tmo (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .alt_mode  (alt_mode),
        .alt_units (alt_units),
        .expire    (expire)
    );

    wdg_alarm #(
        .PULSE_CYC (PULSE_CYC),
        .FAULT_DLY (FAULT_DLY)
    ) u_alm (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .expire  (expire),
        .warn_n  (warn_n),
        .fault_n (fault_n)
    );

endmodule

// File: rtl/wdg_guard_chk.sv
// Module: wdg_guard_chk
// Port-level properties of wdg_pulse_guard, attached by bind below.
// Assumes: the same parameter values as the bound instance.
module wdg_guard_chk #(
    parameter int PULSE_CYC = 250000
) (
    input logic clk,
    input logic rst_n,
    input logic wd_level,
    input logic wd_float,
    input logic sys_rst_act,
    input logic batt_act,
    input logic man_rst,
    input logic warn_n,
    input logic fault_n
);

    logic        run_ok;
    int unsigned low_run;

    assign run_ok = !wd_float && !sys_rst_act && !batt_act && !man_rst;

    // Purpose: length of the current low run of warn_n.
    always_ff @(posedge clk) begin
        if (!rst_n || warn_n) begin
            low_run <= 0;
        end else begin
            low_run <= low_run + 1;
        end
    end

    AST_PULSE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= PULSE_CYC); // R4

    AST_FAULT_TRAILS_WARN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_n) |-> (!warn_n && $past(!warn_n))); // R5

    AST_CHANGE_RAISES_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (run_ok && (wd_level != $past(wd_level))) |=> fault_n); // R6

    AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_ok && !fault_n && (wd_level == $past(wd_level))) |=> !fault_n); // R6

    AST_FLOAT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        wd_float |=> (warn_n && fault_n)); // R8

    AST_HOST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst_act || batt_act) |=> (warn_n && fault_n)); // R9

    AST_MANUAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        man_rst |=> (warn_n && fault_n)); // R10

endmodule

bind wdg_pulse_guard wdg_guard_chk #(
    .PULSE_CYC (PULSE_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wd_level    (wd_level),
    .wd_float    (wd_float),
    .sys_rst_act (sys_rst_act),
    .batt_act    (batt_act),
    .man_rst     (man_rst),
    .warn_n      (warn_n),
    .fault_n     (fault_n)
);

// File: tb/wdg_pulse_guard_test.sv
// Bench for wdg_pulse_guard: directed corner cases followed by seeded
// random activity, compared every cycle with a requirement-level model.
module wdg_pulse_guard_test;

    localparam int TDIV  = 4;
    localparam int DEFT  = 20;
    localparam int STEP  = 3;
    localparam int SW    = 4;
    localparam int PULSE = 5;
    localparam int FDLY  = 2;
    localparam int NDEF  = DEFT * TDIV;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wd_level = 1'b0;
    logic          wd_float = 1'b0;
    logic          alt_mode = 1'b0;
    logic [SW-1:0] alt_units = '0;
    logic          sys_rst_act = 1'b0;
    logic          batt_act = 1'b0;
    logic          man_rst = 1'b0;
    logic          warn_n;
    logic          fault_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string cur_tag = "R1";

    // model state
    int m_lv = 0, m_el = 0, m_warn = 1, m_wl = 0, m_dly = 0, m_fault = 1;

    always #2 clk = ~clk;

    wdg_pulse_guard #(
        .TICK_DIV (TDIV), .DEF_TICKS (DEFT), .ALT_STEP (STEP),
        .SET_W (SW), .PULSE_CYC (PULSE), .FAULT_DLY (FDLY)
    ) uut (
        .clk (clk), .rst_n (rst_n), .wd_level (wd_level), .wd_float (wd_float),
        .alt_mode (alt_mode), .alt_units (alt_units), .sys_rst_act (sys_rst_act),
        .batt_act (batt_act), .man_rst (man_rst), .warn_n (warn_n), .fault_n (fault_n)
    );

    function automatic int limit_ticks(input logic am, input logic [SW-1:0] u);
        int e;
        e = (u == 0) ? 1 : int'(u);
        return am ? e * STEP : DEFT;
    endfunction

    task automatic chk(input int act, input int exp, input string tag, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Requirement-level model of one clock edge (R1..R11).
    task automatic model_step();
        bit dis, kick, expire;
        int lim;
        dis = !rst_n || wd_float || sys_rst_act || batt_act || man_rst;
        if (dis) begin
            m_lv = int'(wd_level); m_el = 0; m_warn = 1; m_wl = 0; m_dly = 0; m_fault = 1;
        end else begin
            kick = (int'(wd_level) != m_lv);
            m_lv = int'(wd_level);
            lim = limit_ticks(alt_mode, alt_units);
            expire = !kick && (m_el % TDIV == TDIV - 1) && (m_el / TDIV + 1 >= lim);
            if (expire) begin
                m_warn = 0; m_wl = PULSE - 1;
            end else if (m_warn == 0) begin
                if (m_wl == 0) m_warn = 1; else m_wl--;
            end
            if (kick) begin
                m_dly = 0; m_fault = 1;
            end else begin
                if (m_dly != 0) begin
                    if (m_dly == 1) m_fault = 0;
                    m_dly--;
                end
                if (expire) m_dly = FDLY;
            end
            m_el = (kick || expire) ? 0 : m_el + 1;
        end
    endtask

    task automatic tick1();
        @(posedge clk);
        model_step();
        #1;
        chk(int'(warn_n), m_warn, cur_tag, "model warn_n");
        chk(int'(fault_n), m_fault, cur_tag, "model fault_n");
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick1();
    endtask

    task automatic toggle();
        wd_level = ~wd_level;
    endtask

    // Disable source sel: 0 float (R8), 1 system reset, 2 battery (R9), 3 manual (R10).
    task automatic disable_case(input int sel, input string tag);
        cur_tag = tag;
        alt_mode = 1'b1; alt_units = 4'd1;
        toggle(); ticks(20);
        chk(int'(fault_n), 0, tag, "fault low before disable");
        case (sel)
            0: wd_float = 1'b1;
            1: sys_rst_act = 1'b1;
            2: batt_act = 1'b1;
            default: man_rst = 1'b1;
        endcase
        tick1();
        chk(int'(warn_n), 1, tag, "warn_n high while off");
        chk(int'(fault_n), 1, tag, "fault_n high while off");
        for (int i = 0; i < 30; i++) begin
            if (i % 3 == 0) toggle();
            tick1();
            chk(int'(warn_n & fault_n), 1, tag, "outputs high, changes ignored");
        end
        wd_float = 1'b0; sys_rst_act = 1'b0; batt_act = 1'b0; man_rst = 1'b0;
        ticks(11);
        chk(int'(warn_n), 1, tag, "no expiry before fresh timeout");
        tick1();
        chk(int'(warn_n), 0, tag, "expiry 12 edges after release");
        toggle(); tick1();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h0C0FFEE5);

        // R1: reset state
        cur_tag = "R1";
        ticks(3);
        chk(int'(warn_n), 1, "R1", "warn_n in reset");
        chk(int'(fault_n), 1, "R1", "fault_n in reset");
        rst_n = 1'b1;

        // R3: default timeout counted from last reset edge
        cur_tag = "R3";
        ticks(NDEF - 1);
        chk(int'(warn_n), 1, "R3", "no expiry before N");
        tick1();
        chk(int'(warn_n), 0, "R3", "expiry at N");

        // R4, R5: pulse width and fault delay
        cur_tag = "R5";
        for (int i = 1; i <= 6; i++) begin
            tick1();
            chk(int'(warn_n), (i >= PULSE) ? 1 : 0, "R4", "warning pulse width");
            chk(int'(fault_n), (i < FDLY) ? 1 : 0, "R5", "fault after delay");
        end

        // R7: repeated expiry while fault stays low
        cur_tag = "R7";
        ticks(NDEF - 7);
        chk(int'(warn_n), 1, "R7", "between pulses");
        chk(int'(fault_n), 0, "R7", "fault held");
        tick1();
        chk(int'(warn_n), 0, "R7", "second pulse at 2N");
        chk(int'(fault_n), 0, "R7", "fault still low");

        // R6: change returns fault high
        cur_tag = "R6";
        toggle(); tick1();
        chk(int'(fault_n), 1, "R6", "fault cleared by change");
        chk(int'(warn_n), 0, "R4", "pulse not shortened by change");

        // R2: one-cycle pulse gives two restarts
        cur_tag = "R2";
        ticks(40);
        toggle(); tick1(); toggle(); tick1();
        ticks(NDEF - 1);
        chk(int'(warn_n), 1, "R2", "restart by falling edge");
        tick1();
        chk(int'(warn_n), 0, "R2", "expiry N after last edge");

        // R6: change in the delay window cancels the fault
        cur_tag = "R6";
        toggle(); tick1();
        for (int i = 0; i < 10; i++) begin
            tick1();
            chk(int'(fault_n), 1, "R6", "pending fault cancelled");
        end

        // R3: alternate timeouts, setting 2 and setting 0
        cur_tag = "R3";
        alt_mode = 1'b1; alt_units = 4'd2;
        toggle(); tick1();
        ticks(2 * STEP * TDIV - 1);
        chk(int'(warn_n), 1, "R3", "alt 2 before expiry");
        tick1();
        chk(int'(warn_n), 0, "R3", "alt 2 expiry");
        alt_units = 4'd0;
        toggle(); tick1();
        ticks(STEP * TDIV - 1);
        chk(int'(warn_n), 1, "R3", "alt 0 before expiry");
        tick1();
        chk(int'(warn_n), 0, "R3", "alt 0 counts as 1");
        ticks(10);

        // R11: limit lowered below elapsed ticks
        cur_tag = "R11";
        alt_mode = 1'b0;
        toggle(); tick1();
        ticks(30);
        alt_mode = 1'b1; alt_units = 4'd1;
        tick1();
        chk(int'(warn_n), 1, "R11", "no expiry mid tick");
        tick1();
        chk(int'(warn_n), 0, "R11", "expiry at next tick boundary");
        ticks(10);

        disable_case(0, "R8");
        disable_case(1, "R9");
        disable_case(2, "R9");
        disable_case(3, "R10");

        // Random activity against the model (R2 R3 R4 R5 R6 R7 R11)
        cur_tag = "R7 random";
        for (int i = 0; i < 5000; i++) begin
            if ($urandom % 70 == 0) toggle();
            wd_float    = ($urandom % 150 == 0);
            sys_rst_act = ($urandom % 300 == 0);
            batt_act    = ($urandom % 300 == 0);
            man_rst     = ($urandom % 300 == 0);
            if ($urandom % 250 == 0) alt_mode = ~alt_mode;
            if ($urandom % 250 == 0) alt_units = SW'($urandom);
            tick1();
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule